// File: doc/BRIEF.md
# Five-Voice Wavetable Tone Generator

This block produces the tone part of a small wavetable sound source. Five voices each play a looped table of 32 signed 8-bit samples. Voices 1 to 3 each read their own table. Voices 4 and 5 both read a fourth, shared table. Each voice's pitch comes from a 12-bit period counter that advances a 5-bit sample index. A larger period gives a lower tone. A global 2-bit rate mode can speed every voice up by 16 or by 256.

Each voice's current sample is scaled by a linear 4-bit volume and gated by an enable bit. The five contributions are then summed into one registered signed mix. All register values come from an outside bus interface as plain levels:

- periods
- volumes
- enable mask
- rate mode
- the restart-on-write option

That interface also supplies a one-cycle strobe per voice each time that voice's period register is written. When the restart option is set, the strobe returns the voice's playback to sample 0.

The block does not hold the wave memory. It presents one 7-bit read address per voice and takes back the addressed sample in the same cycle. This means the memory must be read combinationally. All timing is paced by a clock-enable input.

Top module: `wavetable_tone_gen`

## Requirements
- R1: For each voice v, the read address is {table, index}. The table is in bits 6:5 and the index in bits 4:0. Voices 1, 2 and 3 use tables 0, 1 and 2. Voices 4 and 5 both use table 3. The index counts 0 to 31 and then wraps to 0.
- R2: In rate mode 00, each voice's counter decrements on each enabled cycle. When an enabled cycle finds the counter at 0, the counter reloads the period P and the index advances by one. After the first step, the index therefore advances once every P+1 enabled cycles.
- R3: Rate mode 01 uses P shifted right by 8 as the reload value. Rate modes 10 and 11 both use P shifted right by 4.
- R4: A period write strobe for a voice has an effect only while restart mode is set. In that case, at the next edge the voice's index becomes 0 and its counter loads the reload value of the period presented with the strobe, whatever the clock enable is. With restart mode clear, the strobe changes nothing.
- R5: A voice's contribution is floor(sample × volume / 16). The sample is taken as signed and the volume as unsigned 0 to 15. Volume 0 contributes 0.
- R6: Enable mask bit v−1 gates voice v. A clear bit removes the voice from the mix, but the voice keeps stepping.
- R7: The output is an 11-bit signed register. On each enabled cycle it loads the sum of the contributions of the samples addressed in that cycle. On all other cycles it holds.
- R8: Asserting reset clears every index, every counter and the mix at once. Release takes effect on the third rising edge after reset goes high; until then the state stays cleared.
- R9: In a cycle with the clock enable low and no restarting strobe, no index and no counter changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en_i | input | 1 | Step enable for counters and mix |
| period_i | input | 60 | Five 12-bit periods, voice 1 in bits 11:0 |
| period_wr_i | input | 5 | Per-voice period write strobe, bit 0 for voice 1 |
| volume_i | input | 20 | Five 4-bit volumes, voice 1 in bits 3:0 |
| enable_i | input | 5 | Voice enable mask, bit 0 for voice 1 |
| rate_mode_i | input | 2 | Step rate mode (00 x1, 01 x256, 1x x16) |
| restart_mode_i | input | 1 | Period writes restart playback when set |
| rd_addr_o | output | 35 | Five 7-bit wave-memory read addresses |
| sample_i | input | 40 | Five signed 8-bit samples read at rd_addr_o |
| mix_o | output | 11 | Signed sum of the enabled, scaled voices |

## Verification
Index and counter changes appear right after the rising edge that sees the enable or a restarting strobe, so a strobe shows up one cycle later. The mix register loads at an enabled edge and is built from the samples addressed just before that edge, so it lags the index it reflects by one step. In the cycles after reset release, both results show the two-edge synchronizer delay before anything moves. The bench keeps a behavioural model that updates on every rising edge under these rules. It compares the addresses and the mix with that model at every falling edge, so each result is read half a cycle after the edge that is meant to produce it.

// File: rtl/wtg_pkg.sv
package wtg_pkg;

  // Step-rate selection decoded by every voice
  typedef enum logic [1:0] {
    RATE_X1      = 2'b00,
    RATE_X256    = 2'b01,
    RATE_X16     = 2'b10,
    RATE_X16_ALT = 2'b11
  } rate_mode_e;

  // Right shifts applied to the period in the faster modes
  localparam int unsigned SHIFT_X16  = 4;
  localparam int unsigned SHIFT_X256 = 8;

endpackage

// File: rtl/wtg_rst_sync.sv
module wtg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync_o
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_n_sync_o = stage2_q;

endmodule

// File: rtl/wtg_voice_stepper.sv
module wtg_voice_stepper #(
  parameter int PER_W = 12,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en_i,
  input  logic [PER_W-1:0] period_i,
  input  logic [1:0]       rate_mode_i,
  input  logic             restart_i,
  output logic [IDX_W-1:0] idx_o
);

  import wtg_pkg::*;

  logic [PER_W-1:0] cnt_q, cnt_d, reload;
  logic [IDX_W-1:0] idx_q, idx_d;

  // Faster modes shorten the reload value instead of adding a prescaler
  always_comb begin
    unique case (rate_mode_e'(rate_mode_i))
      RATE_X256:              reload = period_i >> SHIFT_X256;
      RATE_X16, RATE_X16_ALT: reload = period_i >> SHIFT_X16;
      default:                reload = period_i;
    endcase
  end

  always_comb begin
    cnt_d = cnt_q;
    idx_d = idx_q;
    if (restart_i) begin
      cnt_d = reload;
      idx_d = '0;
    end else if (clk_en_i) begin
      if (cnt_q == '0) begin
        cnt_d = reload;
        idx_d = idx_q + IDX_W'(1);
      end else begin
        cnt_d = cnt_q - PER_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      idx_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      idx_q <= idx_d;
    end
  end

  assign idx_o = idx_q;

endmodule

// File: rtl/wtg_voice_scale.sv
module wtg_voice_scale #(
  parameter int SMP_W = 8,
  parameter int VOL_W = 4,
  parameter int SHIFT = 4,
  parameter int OUT_W = SMP_W + VOL_W + 1 - SHIFT
) (
  input  logic signed [SMP_W-1:0] sample_i,
  input  logic        [VOL_W-1:0] vol_i,
  input  logic                    en_i,
  output logic signed [OUT_W-1:0] level_o
);

  localparam int PROD_W = SMP_W + VOL_W + 1;

  logic signed [PROD_W-1:0] prod;

  always_comb begin
    prod    = PROD_W'(sample_i) * PROD_W'($signed({1'b0, vol_i}));
    level_o = en_i ? OUT_W'(prod >>> SHIFT) : '0;
  end

endmodule

// File: rtl/wtg_mix_accum.sv
module wtg_mix_accum #(
  parameter int N     = 5,
  parameter int LVL_W = 9,
  parameter int MIX_W = 11
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clk_en_i,
  input  logic [N*LVL_W-1:0]      levels_i,
  output logic signed [MIX_W-1:0] mix_o
);

  logic signed [MIX_W-1:0] sum_d, mix_q;

  always_comb begin
    sum_d = '0;
    for (int v = 0; v < N; v++) begin
      sum_d = sum_d + MIX_W'($signed(levels_i[v*LVL_W +: LVL_W]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mix_q <= '0;
    end else if (clk_en_i) begin
      mix_q <= sum_d;
    end
  end

  assign mix_o = mix_q;

endmodule

// File: rtl/wavetable_tone_gen.sv
module wavetable_tone_gen #(
  parameter  int NUM_VOICES = 5,
  parameter  int PER_W      = 12,
  parameter  int IDX_W      = 5,
  parameter  int SMP_W      = 8,
  parameter  int VOL_W      = 4,
  parameter  int VOL_SHIFT  = 4,
  parameter  int MIX_W      = 11,
  localparam int TBL_W      = $clog2(NUM_VOICES - 1),
  localparam int ADDR_W     = TBL_W + IDX_W
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           clk_en_i,
  input  logic [NUM_VOICES*PER_W-1:0]    period_i,
  input  logic [NUM_VOICES-1:0]          period_wr_i,
  input  logic [NUM_VOICES*VOL_W-1:0]    volume_i,
  input  logic [NUM_VOICES-1:0]          enable_i,
  input  logic [1:0]                     rate_mode_i,
  input  logic                           restart_mode_i,
  output logic [NUM_VOICES*ADDR_W-1:0]   rd_addr_o,
  input  logic [NUM_VOICES*SMP_W-1:0]    sample_i,
  output logic signed [MIX_W-1:0]        mix_o
);

  localparam int LVL_W = SMP_W + VOL_W + 1 - VOL_SHIFT;

  logic                          rst_n_int;
  logic [NUM_VOICES*LVL_W-1:0]   levels;

  wtg_rst_sync u_rst_sync (
    .clk          (clk),
    .rst_n        (rst_n),
    .rst_n_sync_o (rst_n_int)
  );

  for (genvar v = 0; v < NUM_VOICES; v++) begin : g_voice
    // The last two voices share the final table
    localparam int TBL = (v < NUM_VOICES - 1) ? v : NUM_VOICES - 2;

    logic [IDX_W-1:0] idx;

    wtg_voice_stepper #(
      .PER_W (PER_W),
      .IDX_W (IDX_W)
    ) u_stepper (
      .clk         (clk),
      .rst_n       (rst_n_int),
      .clk_en_i    (clk_en_i),
      .period_i    (period_i[v*PER_W +: PER_W]),
      .rate_mode_i (rate_mode_i),
      .restart_i   (restart_mode_i & period_wr_i[v]),
      .idx_o       (idx)
    );

    assign rd_addr_o[v*ADDR_W +: ADDR_W] = {TBL_W'(TBL), idx};

    wtg_voice_scale #(
      .SMP_W (SMP_W),
      .VOL_W (VOL_W),
      .SHIFT (VOL_SHIFT),
      .OUT_W (LVL_W)
    ) u_scale (
      .sample_i ($signed(sample_i[v*SMP_W +: SMP_W])),
      .vol_i    (volume_i[v*VOL_W +: VOL_W]),
      .en_i     (enable_i[v]),
      .level_o  (levels[v*LVL_W +: LVL_W])
    );
  end

  wtg_mix_accum #(
    .N     (NUM_VOICES),
    .LVL_W (LVL_W),
    .MIX_W (MIX_W)
  ) u_mix (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .clk_en_i (clk_en_i),
    .levels_i (levels),
    .mix_o    (mix_o)
  );

endmodule

// File: rtl/wtg_tone_checker.sv
module wtg_tone_checker #(
  parameter int N      = 5,
  parameter int IDX_W  = 5,
  parameter int ADDR_W = 7,
  parameter int VOL_W  = 4,
  parameter int MIX_W  = 11
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    clk_en_i,
  input logic [N-1:0]            period_wr_i,
  input logic                    restart_mode_i,
  input logic [N-1:0]            enable_i,
  input logic [N*VOL_W-1:0]      volume_i,
  input logic [N*ADDR_W-1:0]     rd_addr_o,
  input logic signed [MIX_W-1:0] mix_o
);

  logic restart_any;
  assign restart_any = restart_mode_i && (|period_wr_i);

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_i && !restart_any) |=> $stable(rd_addr_o));

  p_restart_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_mode_i && period_wr_i[0]) |=> (rd_addr_o[IDX_W-1:0] == '0));

  p_step_by_one_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en_i && !restart_any) |=>
      ((rd_addr_o[IDX_W-1:0] == $past(rd_addr_o[IDX_W-1:0])) ||
       (rd_addr_o[IDX_W-1:0] == IDX_W'($past(rd_addr_o[IDX_W-1:0]) + 1'b1))));

  p_mix_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en_i |=> $stable(mix_o));

  p_mask_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en_i && enable_i == '0) |=> (mix_o == '0));

  p_mute_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en_i && volume_i == '0) |=> (mix_o == '0));

endmodule

bind wavetable_tone_gen wtg_tone_checker #(
  .N      (NUM_VOICES),
  .IDX_W  (IDX_W),
  .ADDR_W (ADDR_W),
  .VOL_W  (VOL_W),
  .MIX_W  (MIX_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .clk_en_i       (clk_en_i),
  .period_wr_i    (period_wr_i),
  .restart_mode_i (restart_mode_i),
  .enable_i       (enable_i),
  .volume_i       (volume_i),
  .rd_addr_o      (rd_addr_o),
  .mix_o          (mix_o)
);

// File: tb/wavetable_tone_gen_tb.sv
`timescale 1ns/1ps
module wavetable_tone_gen_tb;

  localparam int N = 5, PER_W = 12, IDX_W = 5, SMP_W = 8, VOL_W = 4, MIX_W = 11, ADDR_W = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clk_en = 1'b0;
  logic [N*PER_W-1:0] period = '0;
  logic [N-1:0] pwr = '0;
  logic [N*VOL_W-1:0] vol = '0;
  logic [N-1:0] en = '0;
  logic [1:0] rate = 2'b00;
  logic rmode = 1'b0;
  logic [N*ADDR_W-1:0] rd_addr;
  logic [N*SMP_W-1:0] sample;
  logic signed [MIX_W-1:0] mix;

  logic signed [7:0] mem [128];

  int total = 0, bad = 0;
  string tag = "R8 reset";

  int m_cnt [N];
  int m_idx [N];
  int m_mix, m_rel, acc;

  always #4 clk = ~clk;

  wavetable_tone_gen u_dut (
    .clk (clk), .rst_n (rst_n), .clk_en_i (clk_en), .period_i (period),
    .period_wr_i (pwr), .volume_i (vol), .enable_i (en), .rate_mode_i (rate),
    .restart_mode_i (rmode), .rd_addr_o (rd_addr), .sample_i (sample), .mix_o (mix)
  );

  // Wave memory with a combinational read
  always_comb begin
    for (int v = 0; v < N; v++) sample[v*SMP_W +: SMP_W] = mem[rd_addr[v*ADDR_W +: ADDR_W]];
  end

  function automatic int tbl_of(int v);
    return (v < N - 1) ? v : N - 2;
  endfunction

  function automatic int reload_of(int p, logic [1:0] r);
    if (r == 2'b01) return p >> 8;
    if (r[1]) return p >> 4;
    return p;
  endfunction

  // Behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || m_rel < 2) begin
      if (!rst_n) m_rel = 0; else m_rel++;
      m_mix = 0;
      for (int v = 0; v < N; v++) begin m_cnt[v] = 0; m_idx[v] = 0; end
    end else begin
      if (clk_en) begin
        acc = 0;
        for (int v = 0; v < N; v++)
          if (en[v]) acc += (int'(mem[tbl_of(v)*32 + m_idx[v]]) * int'(vol[v*VOL_W +: VOL_W])) >>> 4;
        m_mix = acc;
      end
      for (int v = 0; v < N; v++) begin
        if (rmode && pwr[v]) begin
          m_idx[v] = 0;
          m_cnt[v] = reload_of(int'(period[v*PER_W +: PER_W]), rate);
        end else if (clk_en) begin
          if (m_cnt[v] == 0) begin
            m_cnt[v] = reload_of(int'(period[v*PER_W +: PER_W]), rate);
            m_idx[v] = (m_idx[v] + 1) % 32;
          end else m_cnt[v]--;
        end
      end
    end
  end

  task automatic check(bit ok, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Per-cycle comparison half a cycle after each rising edge
  always @(negedge clk) begin
    for (int v = 0; v < N; v++)
      check(int'(rd_addr[v*ADDR_W +: ADDR_W]) == tbl_of(v)*32 + m_idx[v],
            $sformatf("R1 address voice %0d", v + 1),
            int'(rd_addr[v*ADDR_W +: ADDR_W]), tbl_of(v)*32 + m_idx[v]);
    check(int'(mix) == m_mix, "R7 mix", int'(mix), m_mix);
  end

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_period(int v, int p);
    period[v*PER_W +: PER_W] = PER_W'(p);
  endtask

  task automatic strobe(int v, int p);
    @(negedge clk);
    set_period(v, p);
    pwr[v] = 1'b1;
    @(negedge clk);
    pwr = '0;
  endtask

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = 8'((i * 53 + (i / 32) * 71) ^ (i * 3));
    mem[3] = -8'sd128; mem[40] = 8'sd127; mem[100] = -8'sd128; mem[101] = -8'sd128;

    // R8: reset state and synchronized release
    cycles(3);
    check(mix == '0, "R8 mix cleared in reset", int'(mix), 0);
    check(rd_addr[IDX_W-1:0] == '0, "R8 index cleared in reset", int'(rd_addr[IDX_W-1:0]), 0);
    clk_en = 1'b1;
    rst_n = 1'b1;
    cycles(2);
    check(rd_addr[IDX_W-1:0] == '0, "R8 index held during release", int'(rd_addr[IDX_W-1:0]), 0);

    // R1 R2 R5 R7: normal rate, varied periods and volumes
    tag = "R2 normal rate";
    set_period(0, 0); set_period(1, 1); set_period(2, 2); set_period(3, 5); set_period(4, 7);
    vol = {4'd15, 4'd9, 4'd1, 4'd7, 4'd15};
    en = 5'b11111;
    cycles(400);

    // R9: sparse clock enable
    tag = "R9 gated enable";
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      clk_en = (i % 3 == 0);
    end
    @(negedge clk);
    clk_en = 1'b1;

    // R6: enable mask patterns
    tag = "R6 mask";
    en = 5'b10101; cycles(150);
    en = 5'b00000; cycles(60);
    check(mix == '0, "R6 all voices masked", int'(mix), 0);
    en = 5'b11000; cycles(100);
    en = 5'b11111;

    // R3: fast rate modes
    tag = "R3 rate x256";
    set_period(0, 12'h300); set_period(1, 12'h1FF); set_period(2, 12'h0FF); set_period(3, 12'hFFF); set_period(4, 12'h455);
    rate = 2'b01; cycles(300);
    tag = "R3 rate x16";
    rate = 2'b10; cycles(500);
    tag = "R3 rate x16 alt";
    rate = 2'b11; cycles(300);
    rate = 2'b00;
    set_period(0, 3); set_period(1, 4); set_period(2, 6); set_period(3, 2); set_period(4, 9);
    cycles(80);

    // R4: period writes with restart mode clear, then set
    tag = "R4 no restart";
    strobe(2, 6); strobe(4, 9); cycles(40);
    tag = "R4 restart";
    rmode = 1'b1;
    cycles(13);
    strobe(0, 3);
    check(rd_addr[IDX_W-1:0] == '0, "R4 voice 1 index restarted", int'(rd_addr[IDX_W-1:0]), 0);
    cycles(7);
    clk_en = 1'b0;
    strobe(4, 11);
    check(rd_addr[4*ADDR_W +: IDX_W] == '0, "R4 voice 5 restart with enable low", int'(rd_addr[4*ADDR_W +: IDX_W]), 0);
    cycles(5);
    clk_en = 1'b1;
    cycles(9);
    strobe(3, 2);
    cycles(100);
    rmode = 1'b0;

    // R5: volume extremes
    tag = "R5 volume zero";
    vol = '0; cycles(60);
    check(mix == '0, "R5 all volumes zero", int'(mix), 0);
    tag = "R5 volume full";
    vol = {N{4'd15}}; cycles(200);

    // R8: reset asserted mid-run clears state
    tag = "R8 reset again";
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(mix == '0, "R8 asynchronous clear of mix", int'(mix), 0);
    cycles(3);
    rst_n = 1'b1;
    cycles(50);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog: run did not finish actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule